// File: doc/BRIEF.md
# Calibrated One-Second Prescaler for a Real-Time Clock

This block turns a stream of single-cycle oscillator tick pulses (nominally 32,768 per second) into a one-second enable. It also produces a marker on each minute boundary for the time-of-day counters downstream. Crystal error is trimmed digitally over a repeating calibration window of 64 minutes. In the leading minutes of that window, the last second of each affected minute is made shorter or longer by a fixed number of oscillator ticks. The correction is therefore spread evenly and never needs a second clock.

Software supplies a signed calibration byte, a stop bit and a frequency-test bit. The calibration byte is taken only at the start of each 64-minute window. For factory trimming, the block can place a 512 Hz square wave on data bit 0 while the seconds register is read. That square wave is taken from the raw, uncorrected divider, so it shows the true crystal error. The frequency-test bit clears itself when power fails.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: While rstN is low and in the first cycle after it, secTick, minuteMark and freqDrive are 0; the frequency-test bit is cleared, and all counters start from zero.
- R2: With no correction in force, secTick pulses once every 2^DIV_W counted oscillator ticks (32,768 by default), and minuteMark pulses together with every SEC_PER_MIN-th secTick (60 by default).
- R3: Bits CAL_W-1:0 of calByte hold a magnitude N and bit CAL_W holds the sign, with 1 meaning speed up and 0 meaning slow down. Only minute indices 0 to 2N-1 of the MIN_PER_CYC-minute window are corrected; all other minutes keep nominal length.
- R4: For a positive sign, the last second of each corrected minute lasts 2^DIV_W - POS_EXTRA ticks (256 fewer by default, so each step adds 512 counts per window).
- R5: For a negative sign, the last second of each corrected minute lasts 2^DIV_W + NEG_SKIP ticks (128 more by default, so each step removes 256 counts per window).
- R6: calByte is sampled on the first counted tick of each window, including the first one after reset. A change at any other time takes effect only when the next window starts.
- R7: While stopOsc is 1, oscillator ticks are ignored: every counter holds its value, and secTick and freqDrive stay 0.
- R8: freqDrive equals the frequency-test bit AND NOT stopOsc AND secRead. While freqDrive is 1, freqOut follows bit TEST_BIT of the raw divider (512 Hz by default); otherwise freqOut is 0.
- R9: The raw divider counts every tick that is not stopped, whatever the calibration, so calibration never changes the test frequency.
- R10: A clock edge with ftWrEn high loads ftWrData into the frequency-test bit. powerFail high clears the bit at the next edge and overrides a write in the same cycle.
- R11: secTick and minuteMark are one-clock pulses. They appear in the clock cycle after the edge that samples the completing oscillator tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscTick | input | 1 | One-cycle pulse per oscillator period |
| calByte | input | CAL_W+1 | Sign (top bit) and calibration magnitude |
| stopOsc | input | 1 | Freezes the prescaler when 1 |
| ftWrEn | input | 1 | Write strobe for the frequency-test bit |
| ftWrData | input | 1 | Value written to the frequency-test bit |
| secRead | input | 1 | High while the seconds register is read |
| powerFail | input | 1 | Power-fail indication, clears frequency test |
| secTick | output | 1 | One-second enable pulse |
| minuteMark | output | 1 | Pulse on the minute boundary |
| freqOut | output | 1 | Test square wave for data bit 0 |
| freqDrive | output | 1 | High when freqOut should drive data bit 0 |

## Verification
The bench builds the block with DIV_W=4, SEC_PER_MIN=4, POS_EXTRA=4, NEG_SKIP=2 and TEST_BIT=1, and keeps the 64-minute window. One full calibration window then takes 4,096 counted ticks, so several complete windows run, each under a different sign and magnitude. These include magnitude 31, which corrects 62 of the 64 minutes, and magnitude 0. The shortened and lengthened last seconds stay short enough to count tick by tick. The 2:1 ratio between the added and removed counts is kept. Calibration changes in the middle of a window, stop periods and power-fail events come at random points, so the sampling at the window start is exercised against all of them.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  // Strobes from the control half to the divider datapath, valid for one clk
  typedef struct packed {
    logic adv;       // count this oscillator tick in the seconds divider
    logic jump;      // positive correction: advance the divider by extra counts
    logic rawAdv;    // count this tick in the raw, uncorrected divider
    logic testGate;  // route the raw test bit to the data line
  } calStrobe_t;

endpackage

// File: rtl/rtc_cal_dpath.sv
module rtc_cal_dpath
  import rtc_cal_pkg::*;
#(
  parameter int DIV_W     = 15,
  parameter int POS_EXTRA = 256,
  parameter int TEST_BIT  = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  calStrobe_t strb,
  output logic       secAtZero,
  output logic       secAtMax,
  output logic       secTick,
  output logic       freqOut
);

  localparam logic [DIV_W-1:0] JUMP_LOAD = DIV_W'(POS_EXTRA + 1);

  logic [DIV_W-1:0] secCnt;
  logic [DIV_W-1:0] rawDiv;
  logic             secTickQ;

  assign secAtZero = (secCnt == '0);
  assign secAtMax  = &secCnt;

  // Seconds divider that carries the correction
  always_ff @(posedge clk) begin
    if (!rstN) begin
      secCnt   <= '0;
      secTickQ <= 1'b0;
    end else begin
      secTickQ <= strb.adv && secAtMax;
      if (strb.jump)     secCnt <= JUMP_LOAD;
      else if (strb.adv) secCnt <= secCnt + 1'b1;
    end
  end

  // Free-running divider, never touched by the correction
  always_ff @(posedge clk) begin
    if (!rstN)            rawDiv <= '0;
    else if (strb.rawAdv) rawDiv <= rawDiv + 1'b1;
  end

  assign secTick = secTickQ;
  assign freqOut = strb.testGate && rawDiv[TEST_BIT];

  // R11
  sec_tick_follows_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    secTick |-> $past(strb.adv));

  // R9
  raw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rawAdv |=> $stable(rawDiv));

  // R7
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.adv && !strb.jump) |=> $stable(secCnt));

endmodule

// File: rtl/rtc_cal_ctrl.sv
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_PER_CYC = 64,
  parameter int CAL_W       = 5,
  parameter int NEG_SKIP    = 128
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           oscTick,
  input  logic [CAL_W:0] calByte,
  input  logic           stopOsc,
  input  logic           ftWrEn,
  input  logic           ftWrData,
  input  logic           secRead,
  input  logic           powerFail,
  input  logic           secAtZero,
  input  logic           secAtMax,
  output calStrobe_t     strb,
  output logic           minuteMark,
  output logic           freqDrive
);

  localparam int SEC_W  = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;
  localparam int MIN_W  = (MIN_PER_CYC > 1) ? $clog2(MIN_PER_CYC) : 1;
  localparam int SKIP_W = $clog2(NEG_SKIP + 1);
  localparam logic [SEC_W-1:0]  LAST_SEC = SEC_W'(SEC_PER_MIN - 1);
  localparam logic [MIN_W-1:0]  LAST_MIN = MIN_W'(MIN_PER_CYC - 1);
  localparam logic [SKIP_W-1:0] SKIP_LD  = SKIP_W'(NEG_SKIP);

  logic [SEC_W-1:0]  secOfMin;
  logic [MIN_W-1:0]  minOfCyc;
  logic [CAL_W:0]    calLatch;
  logic [SKIP_W-1:0] skipCnt;
  logic              ftEn;
  logic              minMarkQ;

  logic tickOk, skipping, adv, cycStart, inCalMin, trig, secWrap;

  assign tickOk   = oscTick && !stopOsc;
  assign skipping = (skipCnt != '0);
  assign adv      = tickOk && !skipping;
  // First counted tick of a calibration window
  assign cycStart = adv && secAtZero && (secOfMin == '0) && (minOfCyc == '0);
  // R3: minute index below twice the magnitude is corrected
  assign inCalMin = int'(minOfCyc) < 2 * int'(calLatch[CAL_W-1:0]);
  // Correction is applied at the first tick of the last second of the minute
  assign trig     = adv && secAtZero && (secOfMin == LAST_SEC) && inCalMin;
  assign secWrap  = adv && secAtMax;

  always_comb begin
    strb          = '0;
    strb.adv      = adv;
    strb.jump     = trig && calLatch[CAL_W];
    strb.rawAdv   = tickOk;
    strb.testGate = ftEn && !stopOsc && secRead;
  end

  // Calibration sampling and minute / window position
  always_ff @(posedge clk) begin
    if (!rstN) begin
      calLatch <= '0;
      secOfMin <= '0;
      minOfCyc <= '0;
      minMarkQ <= 1'b0;
    end else begin
      if (cycStart) calLatch <= calByte;
      minMarkQ <= secWrap && (secOfMin == LAST_SEC);
      if (secWrap) begin
        if (secOfMin == LAST_SEC) begin
          secOfMin <= '0;
          minOfCyc <= (minOfCyc == LAST_MIN) ? '0 : minOfCyc + 1'b1;
        end else begin
          secOfMin <= secOfMin + 1'b1;
        end
      end
    end
  end

  // Negative correction: swallow NEG_SKIP ticks after the trigger tick
  always_ff @(posedge clk) begin
    if (!rstN)                        skipCnt <= '0;
    else if (trig && !calLatch[CAL_W]) skipCnt <= SKIP_LD;
    else if (tickOk && skipping)      skipCnt <= skipCnt - 1'b1;
  end

  // Frequency-test bit
  always_ff @(posedge clk) begin
    if (!rstN)       ftEn <= 1'b0;
    else if (powerFail) ftEn <= 1'b0;
    else if (ftWrEn) ftEn <= ftWrData;
  end

  assign minuteMark = minMarkQ;
  assign freqDrive  = strb.testGate;

  // R6
  cal_window_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (minOfCyc != '0) |=> $stable(calLatch));

  // R10
  ft_powerfail_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |=> !ftEn);

  // R5
  jump_not_while_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.jump |-> !skipping);

endmodule

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler
  import rtc_cal_pkg::*;
#(
  parameter int DIV_W       = 15,
  parameter int SEC_PER_MIN = 60,
  parameter int MIN_PER_CYC = 64,
  parameter int CAL_W       = 5,
  parameter int POS_EXTRA   = 256,
  parameter int NEG_SKIP    = 128,
  parameter int TEST_BIT    = 5
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           oscTick,
  input  logic [CAL_W:0] calByte,
  input  logic           stopOsc,
  input  logic           ftWrEn,
  input  logic           ftWrData,
  input  logic           secRead,
  input  logic           powerFail,
  output logic           secTick,
  output logic           minuteMark,
  output logic           freqOut,
  output logic           freqDrive
);

  calStrobe_t strb;
  logic       secAtZero;
  logic       secAtMax;

  rtc_cal_ctrl #(
    .SEC_PER_MIN(SEC_PER_MIN),
    .MIN_PER_CYC(MIN_PER_CYC),
    .CAL_W      (CAL_W),
    .NEG_SKIP   (NEG_SKIP)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .oscTick   (oscTick),
    .calByte   (calByte),
    .stopOsc   (stopOsc),
    .ftWrEn    (ftWrEn),
    .ftWrData  (ftWrData),
    .secRead   (secRead),
    .powerFail (powerFail),
    .secAtZero (secAtZero),
    .secAtMax  (secAtMax),
    .strb      (strb),
    .minuteMark(minuteMark),
    .freqDrive (freqDrive)
  );

  rtc_cal_dpath #(
    .DIV_W    (DIV_W),
    .POS_EXTRA(POS_EXTRA),
    .TEST_BIT (TEST_BIT)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .secAtZero(secAtZero),
    .secAtMax (secAtMax),
    .secTick  (secTick),
    .freqOut  (freqOut)
  );

  // R2
  minute_with_second_chk: assert property (@(posedge clk) disable iff (!rstN)
    minuteMark |-> secTick);

  // R7
  stop_no_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopOsc |=> !secTick);

  // R8
  drive_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    freqDrive |-> (secRead && !stopOsc));

endmodule

// File: tb/sim_rtc_cal_prescaler.sv
module sim_rtc_cal_prescaler;

  localparam int DIV_W = 4;
  localparam int SPM   = 4;
  localparam int MPC   = 64;
  localparam int CAL_W = 5;
  localparam int POSX  = 4;
  localparam int NEGX  = 2;
  localparam int TBIT  = 1;
  localparam int TLEN  = 1 << DIV_W;
  localparam int NTICK = 20000;

  logic clk = 1'b0;
  logic rstN;
  logic oscTick, stopOsc, ftWrEn, ftWrData, secRead, powerFail;
  logic [CAL_W:0] calByte;
  logic secTick, minuteMark, freqOut, freqDrive;

  always #5ns clk = ~clk;

  rtc_cal_prescaler #(
    .DIV_W(DIV_W), .SEC_PER_MIN(SPM), .MIN_PER_CYC(MPC), .CAL_W(CAL_W),
    .POS_EXTRA(POSX), .NEG_SKIP(NEGX), .TEST_BIT(TBIT)
  ) u0 (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .calByte(calByte),
    .stopOsc(stopOsc), .ftWrEn(ftWrEn), .ftWrData(ftWrData),
    .secRead(secRead), .powerFail(powerFail), .secTick(secTick),
    .minuteMark(minuteMark), .freqOut(freqOut), .freqDrive(freqDrive)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state
  int rawM = 0, cntM = 0, secM = 0, minM = 0;
  logic [CAL_W:0] calM = '0;
  bit ftM = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R3/R4/R5: length of a second in oscillator ticks
  function automatic int secLen(input int s, input int m, input logic [CAL_W:0] c);
    if (s == SPM - 1 && m < 2 * int'(c[CAL_W-1:0]))
      return c[CAL_W] ? TLEN - POSX : TLEN + NEGX;
    return TLEN;
  endfunction

  task automatic step();
    bit eSec = 0, eMin = 0, counted;
    string tagS;
    counted = oscTick && !stopOsc;
    if (powerFail) ftM = 0;
    else if (ftWrEn) ftM = ftWrData;
    if (!oscTick) tagS = "R11";
    else if (stopOsc) tagS = "R7";
    else if (calByte != calM) tagS = "R6";
    else if (secM == SPM - 1 && minM < 2 * int'(calM[CAL_W-1:0]))
      tagS = calM[CAL_W] ? "R4" : "R5";
    else if (calM[CAL_W-1:0] != 0) tagS = "R3";
    else tagS = "R2";
    if (counted) begin
      rawM = (rawM + 1) % TLEN;
      if (cntM == 0 && secM == 0 && minM == 0) calM = calByte;
      cntM++;
      if (cntM == secLen(secM, minM, calM)) begin
        eSec = 1;
        eMin = (secM == SPM - 1);
        cntM = 0;
        if (secM == SPM - 1) begin
          secM = 0;
          minM = (minM + 1) % MPC;
        end else secM++;
      end
    end
    @(negedge clk);
    chk(secTick == eSec, tagS, secTick, eSec);
    chk(minuteMark == eMin, "R2 minute", minuteMark, eMin);
    chk(freqDrive == (ftM && !stopOsc && secRead), "R8 drive", freqDrive,
        ftM && !stopOsc && secRead);
    chk(freqOut == (ftM && !stopOsc && secRead && rawM[TBIT]), "R9 test wave",
        freqOut, ftM && !stopOsc && secRead && rawM[TBIT]);
  endtask

  initial begin
    #1500us;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seedV;
    seedV = $urandom(32'd20240611);
    rstN = 0; oscTick = 0; stopOsc = 0; ftWrEn = 1; ftWrData = 1;
    secRead = 1; powerFail = 0; calByte = 6'b100011;
    repeat (4) @(negedge clk);
    // R1: reset holds outputs low even with a write and read pending
    chk(secTick == 0, "R1 secTick", secTick, 0);
    chk(minuteMark == 0, "R1 minuteMark", minuteMark, 0);
    chk(freqDrive == 0, "R1 freqDrive", freqDrive, 0);
    chk(freqOut == 0, "R1 freqOut", freqOut, 0);
    ftWrEn = 0;
    rstN = 1;
    @(negedge clk);
    chk(freqDrive == 0, "R1 after release", freqDrive, 0);

    // R10: write sets the test bit, power fail overrides a write
    ftWrEn = 1; ftWrData = 1; step();
    chk(freqDrive == 1, "R10 write", freqDrive, 1);
    powerFail = 1; step();
    chk(freqDrive == 0, "R10 powerfail wins", freqDrive, 0);
    powerFail = 0; ftWrEn = 1; ftWrData = 1; step();
    ftWrEn = 0; step();

    for (int t = 0; t < NTICK; t++) begin
      case (t)
        0:     calByte = 6'b100011;  // +3
        3000:  calByte = 6'b011111;  // -31
        7000:  calByte = 6'b111111;  // +31
        11000: calByte = 6'b000000;  // none
        14000: calByte = 6'b000001;  // -1
        17000: calByte = 6'b101010;  // +10
        default: if ($urandom % 1500 == 0) calByte = 6'($urandom);
      endcase
      stopOsc   = ($urandom % 16 == 0);
      secRead   = ($urandom % 3 != 0);
      powerFail = ($urandom % 700 == 0);
      ftWrEn    = ($urandom % 300 == 0);
      ftWrData  = 1'($urandom);
      oscTick   = 1;
      step();
      oscTick = 0; ftWrEn = 0; powerFail = 0;
      step();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule